// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up already-synchronized pin inputs before the rest of the pin logic sees them. Each lane holds a filtered output level. When the raw input moves away from that level, the new level is passed on only after it has stayed put for a programmed number of core clock cycles. If the input falls back to the filtered level before then, the attempt is dropped and a later change has to start again from zero.

The hold time of each lane comes from an 8-bit setting with a mantissa and an exponent. A 4-bit count gives the mantissa, and a 4-bit select gives a power-of-two prescale, so the hold time is count × 2^select cycles. Short times can be set in single-cycle steps, and the longest setting is 15 × 2^15 cycles. Software loads a lane's setting by asserting that lane's write strobe with a configuration word, and the setting is taken from bits 11:4 of that word. One word can be written to several lanes in the same cycle.

Top module: `glitch_filter`

## Requirements
- R1: After reset every filtered output is 0 and every lane holds select = 4 and count = 9, so a change of input needs 144 cycles to reach the output.
- R2: A lane write takes the count from cfg_word bits 7:4 and the select from cfg_word bits 11:8. Bits 3:0 have no effect on the filter time.
- R3: With count C > 0 and select S, the output takes the new level at the C × 2^S-th consecutive rising edge at which the raw input differs from the output, and not at any earlier edge.
- R4: With count 0, the output takes a differing raw level at the first rising edge that sees it.
- R5: A rising edge at which the raw input equals the output clears all progress of that lane, so the next change again needs the full C × 2^S edges.
- R6: A write to a lane clears its progress and leaves its output unchanged. If the write lands on the edge at which the output would have changed, the write wins.
- R7: Lanes are independent. A write strobe bit reaches only its own lane, and one lane's input has no effect on another lane's output.
- R8: Select 15 is supported in full. With count 1, the output changes at edge 32768 and not at edge 32767.
- R9: A pulse on the raw input that is shorter than the filter time never reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | NUM_PINS | Per-lane write strobe for the filter setting |
| cfg_word | input | 12 | Configuration word; count in bits 7:4, select in bits 11:8 |
| pin_raw | input | NUM_PINS | Synchronized raw pin levels |
| pin_filt | output | NUM_PINS | Filtered pin levels |

## Verification
The collision that matters is a configuration write landing on the same edge at which the stability counter reaches its target. The bench sets count 4 with select 0 and holds a changed input for three edges. It then raises the lane's write strobe so the write lands on the fourth edge. The bench expects the output to keep its old level on that edge, and to change only after four further edges. A second case lets an input return to the filtered level on a single edge partway through a count. It then expects the full delay to start over.

// File: rtl/glf_pkg.sv
package glf_pkg;
    localparam int SEL_W   = 4;
    localparam int CNT_W   = 4;
    localparam int CNT_LSB = 4;
    localparam int CFG_W   = CNT_LSB + CNT_W + SEL_W;
    localparam int PRE_W   = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } filt_cfg_t;

    localparam filt_cfg_t FILT_CFG_RST = '{sel: SEL_W'(4), cnt: CNT_W'(9)};
endpackage

// File: rtl/glf_prescale.sv
module glf_prescale
    import glf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam logic [SEL_W:0] SHIFT_TOP = (SEL_W+1)'(PRE_W);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] wrap_mask;
    logic [SEL_W:0]   shift_amt;

    always_comb begin
        shift_amt = SHIFT_TOP - {1'b0, sel};
        wrap_mask = {PRE_W{1'b1}} >> shift_amt;
        tick      = run && (pre_q == wrap_mask);
        pre_d     = pre_q;
        if (clr) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = tick ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assert_clear_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !run) |=> $stable(pre_q));
endmodule

// File: rtl/glf_lane.sv
module glf_lane
    import glf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_wr,
    input  filt_cfg_t cfg_in,
    input  logic      raw,
    output logic      filt
);
    typedef struct packed {
        filt_cfg_t        setting;
        logic [CNT_W-1:0] stab;
        logic             level;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     differs;
    logic     pre_clr;
    logic     pre_run;
    logic     tick;
    logic     reached;

    assign differs = (raw != st_q.level);
    assign pre_clr = cfg_wr || !differs;
    assign pre_run = differs && (st_q.setting.cnt != '0);

    glf_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .run   (pre_run),
        .sel   (st_q.setting.sel),
        .tick  (tick)
    );

    always_comb begin
        st_d    = st_q;
        reached = tick && (CNT_W'(st_q.stab + 1'b1) == st_q.setting.cnt);
        if (cfg_wr) begin
            st_d.setting = cfg_in;
            st_d.stab    = '0;
        end else if (!differs) begin
            st_d.stab = '0;
        end else if (st_q.setting.cnt == '0) begin
            st_d.level = raw;
            st_d.stab  = '0;
        end else if (tick) begin
            if (reached) begin
                st_d.level = raw;
                st_d.stab  = '0;
            end else begin
                st_d.stab = st_q.stab + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.setting <= FILT_CFG_RST;
            st_q.stab    <= '0;
            st_q.level   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt = st_q.level;

    assert_moves_to_raw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level != $past(st_q.level)) |-> (!$past(cfg_wr) && ($past(raw) == st_q.level)));

    assert_write_keeps_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> $stable(st_q.level));

    assert_match_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !differs) |=> (st_q.stab == '0));

    assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && differs && st_q.setting.cnt == '0) |=> (st_q.level == $past(raw)));

    assert_stab_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stab == '0) || (st_q.stab < st_q.setting.cnt));
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
    import glf_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] cfg_wr,
    input  logic [CFG_W-1:0]    cfg_word,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_filt
);
    localparam int FIELD_HI = CFG_W - 1;

    filt_cfg_t cfg_field;
    assign cfg_field = filt_cfg_t'(cfg_word[FIELD_HI:CNT_LSB]);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_lane
        glf_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_wr (cfg_wr[g]),
            .cfg_in (cfg_field),
            .raw    (pin_raw[g]),
            .filt   (pin_filt[g])
        );
    end
endmodule

// File: tb/glitch_filter_tb.sv
`timescale 1ns/1ps
module glitch_filter_tb;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] cfg_wr = '0;
    logic [11:0]   cfg_word = '0;
    logic [NP-1:0] pin_raw = '0;
    logic [NP-1:0] pin_filt;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    glitch_filter #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .pin_raw(pin_raw), .pin_filt(pin_filt)
    );

    // vector: [8:5] select, [4:1] count, [0] new level on lane 0
    localparam logic [8:0] VEC [6] = '{
        {4'd0, 4'd1,  1'b1},
        {4'd0, 4'd0,  1'b0},
        {4'd1, 4'd2,  1'b1},
        {4'd3, 4'd5,  1'b0},
        {4'd2, 4'd0,  1'b1},
        {4'd4, 4'd15, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [NP-1:0] mask, input logic [3:0] s,
                             input logic [3:0] c, input logic [3:0] junk);
        cfg_word = {s, c, junk};
        cfg_wr   = mask;
        step(1);
        cfg_wr   = '0;
    endtask

    function automatic int hold_time(input logic [3:0] s, input logic [3:0] c);
        return (c == 0) ? 1 : (int'(c) << s);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 reset output", pin_filt[0], 1'b0);
        check("R1 reset output lanes", |pin_filt, 1'b0);

        // R1: default 4/9 -> 144 edges
        pin_raw[0] = 1'b1;
        step(143);
        check("R1 default edge 143", pin_filt[0], 1'b0);
        step(1);
        check("R1 default edge 144", pin_filt[0], 1'b1);

        // R2: sel 2 count 3 with junk low bits -> 12 edges
        write_cfg(4'b0001, 4'd2, 4'd3, 4'hF);
        pin_raw[0] = 1'b0;
        step(11);
        check("R2 edge 11", pin_filt[0], 1'b1);
        step(1);
        check("R2 edge 12", pin_filt[0], 1'b0);

        // R3/R4 table walk
        foreach (VEC[i]) begin
            automatic logic [3:0] s = VEC[i][8:5];
            automatic logic [3:0] c = VEC[i][4:1];
            automatic logic       l = VEC[i][0];
            automatic int         n = hold_time(s, c);
            write_cfg(4'b0001, s, c, 4'h0);
            pin_raw[0] = l;
            if (n > 1) step(n - 1);
            check((c == 0) ? "R4 before edge" : "R3 before edge", pin_filt[0], ~l);
            step(1);
            check((c == 0) ? "R4 at edge" : "R3 at edge", pin_filt[0], l);
        end

        // R6: write collides with completion edge (lane0 now 0)
        write_cfg(4'b0001, 4'd0, 4'd4, 4'h0);
        pin_raw[0] = 1'b1;
        step(3);
        check("R6 pre-collision", pin_filt[0], 1'b0);
        write_cfg(4'b0001, 4'd0, 4'd4, 4'h0);
        check("R6 write wins", pin_filt[0], 1'b0);
        step(3);
        check("R6 restart edge 3", pin_filt[0], 1'b0);
        step(1);
        check("R6 restart edge 4", pin_filt[0], 1'b1);

        // R5: return to level restarts (lane0 now 1)
        write_cfg(4'b0001, 4'd1, 4'd3, 4'h0);
        pin_raw[0] = 1'b0;
        step(5);
        check("R5 partial", pin_filt[0], 1'b1);
        pin_raw[0] = 1'b1;
        step(1);
        pin_raw[0] = 1'b0;
        step(5);
        check("R5 restart edge 5", pin_filt[0], 1'b1);
        step(1);
        check("R5 restart edge 6", pin_filt[0], 1'b0);

        // R9: short pulse rejected (lane0 now 0)
        write_cfg(4'b0001, 4'd2, 4'd2, 4'h0);
        pin_raw[0] = 1'b1;
        for (int k = 0; k < 7; k++) begin
            step(1);
            check("R9 during pulse", pin_filt[0], 1'b0);
        end
        pin_raw[0] = 1'b0;
        step(8);
        check("R9 after pulse", pin_filt[0], 1'b0);

        // R7: lane independence
        write_cfg(4'b0001, 4'd0, 4'd8, 4'h0);
        write_cfg(4'b0010, 4'd0, 4'd2, 4'h0);
        pin_raw[1:0] = 2'b11;
        step(2);
        check("R7 lane1 fast", pin_filt[1], 1'b1);
        check("R7 lane0 slow", pin_filt[0], 1'b0);
        check("R7 lanes idle", |pin_filt[3:2], 1'b0);
        write_cfg(4'b0010, 4'd0, 4'd2, 4'h0);
        check("R6 lane1 kept", pin_filt[1], 1'b1);
        step(4);
        check("R7 lane0 edge 7", pin_filt[0], 1'b0);
        step(1);
        check("R7 lane0 edge 8", pin_filt[0], 1'b1);

        // R8: select 15 count 1 (lane0 now 1)
        write_cfg(4'b0001, 4'd15, 4'd1, 4'h0);
        pin_raw[0] = 1'b0;
        step(32767);
        check("R8 edge 32767", pin_filt[0], 1'b1);
        step(1);
        check("R8 edge 32768", pin_filt[0], 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule